// File: doc/BRIEF.md
# Bidirectional Arithmetic Shift Unit

This block is a multi-cycle arithmetic shifter for a 16-bit processor datapath. It takes a register operand and a source word. The low six bits of the source word give a signed shift distance. The unit shifts either one 16-bit word or a 32-bit value built from a high and a low register. Condition flags N, Z, V and C come back with the result.

The unit moves the operand one bit position on each clock, so an operation takes as many cycles as the shift distance. The surrounding core pulses `startIn` with the operands applied. It then waits for the one-cycle `doneOut` pulse and takes the result words and flags from that cycle. Fetching operands, writing registers back and decoding instructions all happen outside this block.

Top module: `arith_shift_unit`

## Requirements
- R1: The shift distance is `srcIn[5:0]`, read as a two's complement value from -32 to +31; bits above bit 5 have no effect. A positive value shifts toward the most significant bit (left) and a negative value shifts toward bit 0 (right), by the magnitude of the value.
- R2: A zero distance returns the operand unchanged with C=0 and V=0, and N and Z describe that unchanged operand.
- R3: With `comboMode`=0 (single mode) the word on `hiIn` is shifted and returned on `hiOut`, `loOut` returns `loIn` unchanged, and `oddReg` has no effect.
- R4: With `comboMode`=1 and `oddReg`=1, a right shift rotates the `hiIn` word right by the distance (up to 32 positions), and the result appears on both `hiOut` and `loOut`.
- R5: A right shift copies the sign bit into the vacated upper positions. A left shift fills the vacated lower positions with zeros.
- R6: V is 1 when the sign bit of the shifted quantity changed at any step of a left shift, and 0 after any right shift.
- R7: C holds the last bit shifted out. For a rotate, this is the bit that wrapped from bit 0 to bit 15.
- R8: `doneOut` is high for exactly one cycle. It goes high after the rising clock edge that comes |distance| edges after the edge that sampled `startIn`.
- R9: With `comboMode`=1 and `oddReg`=0, `{hiIn, loIn}` is shifted as one 32-bit value, with `hiIn` as bits 31:16. The result is returned as `{hiOut, loOut}`.
- R10: N equals bit 15 of `hiOut`. Z is 1 only when the whole shifted quantity is zero: 32 bits in combined-even mode, the 16-bit word otherwise.
- R11: After reset `hiOut` and `loOut` are zero and `doneOut` is low. A `startIn` that arrives while an operation is in progress is ignored.
- R12: With `comboMode`=1 and `oddReg`=1, a left shift is an ordinary 16-bit arithmetic left shift of the `hiIn` word, returned on both output words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | Starts an operation when the unit is idle |
| comboMode | input | 1 | 1 = combined 32-bit mode, 0 = single 16-bit mode |
| oddReg | input | 1 | Register number is odd (used only in combined mode) |
| hiIn | input | 16 | Register operand, or high half in combined mode |
| loIn | input | 16 | Low half in combined mode |
| srcIn | input | 16 | Source word; bits 5:0 hold the signed distance |
| hiOut | output | 16 | Result word, or high half of the result |
| loOut | output | 16 | Low half of the result, or pass-through in single mode |
| flagN | output | 1 | Result negative |
| flagZ | output | 1 | Result zero |
| flagV | output | 1 | Sign changed during a left shift |
| flagC | output | 1 | Last bit shifted out |
| doneOut | output | 1 | One-cycle pulse marking a valid result |

## Verification
Two internal faults look alike at the ports: a wrong remaining-step counter and a wrong mode latched at load. Both show up as an error in the shifted value that grows with every step. The counter fault also moves the `doneOut` pulse away from the |distance| edges the requirements fix, so every operation is checked for both its value and its exact latency. A sticky-V or carry-capture fault shows on the flags in the very cycle `doneOut` rises. The bench therefore covers sign flips at the first step, at a later step and at the final step. A load that wrongly accepts a second start while busy shows up as a changed result when that operation completes.

// File: rtl/ash_pkg.sv
package ash_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;   // capture operands and mode
    logic step;   // move one bit position
  } ashCtl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } ashState_e;

endpackage

// File: rtl/ash_ctrl.sv
module ash_ctrl
  import ash_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic [CNT_W-1:0] countIn,
  output ashCtl_t          ctl,
  output logic             doneOut
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  ashState_e        state;
  logic [CNT_W-1:0] remCnt;
  logic [CNT_W-1:0] magNext;

  // Magnitude of the signed distance; the most negative value maps to 2**(CNT_W-1)
  assign magNext = countIn[CNT_W-1] ? (~countIn + ONE) : countIn;

  always_comb begin
    ctl.load = (state == ST_IDLE) && startIn;
    ctl.step = (state == ST_RUN);
  end

  assign doneOut = (state == ST_DONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      remCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startIn) begin
            remCnt <= magNext;
            state  <= (magNext == '0) ? ST_DONE : ST_RUN;
          end
        end
        ST_RUN: begin
          remCnt <= remCnt - ONE;
          if (remCnt == ONE) state <= ST_DONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: completion is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  // R8: every running cycle consumes exactly one position
  assert_step_count_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |=> (remCnt == $past(remCnt) - ONE));

  // R11: a start during a run does not restart the counter
  assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && startIn) |=> (state != ST_IDLE && remCnt != $past(magNext) + ONE));

endmodule

// File: rtl/ash_dp.sv
module ash_dp
  import ash_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ashCtl_t           ctl,
  input  logic              comboIn,
  input  logic              oddIn,
  input  logic              rightIn,
  input  logic [WORD_W-1:0] hiIn,
  input  logic [WORD_W-1:0] loIn,
  output logic [WORD_W-1:0] hiOut,
  output logic [WORD_W-1:0] loOut,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagV,
  output logic              flagC
);

  localparam int DBL_W = 2 * WORD_W;
  localparam int TOP   = DBL_W - 1;

  // 16-bit modes keep the word in the upper half; the lower half stays zero
  logic [DBL_W-1:0]  acc, accNext;
  logic [WORD_W-1:0] loHold;
  logic              modeCombo, modeOdd, goRight;
  logic              vReg, cReg, outBit, vNext;
  logic              wide, rot;

  assign wide = modeCombo & ~modeOdd;
  assign rot  = modeCombo &  modeOdd;

  always_comb begin
    if (!goRight) begin
      accNext = {acc[TOP-1:0], 1'b0};
      outBit  = acc[TOP];
    end else if (wide) begin
      accNext = {acc[TOP], acc[TOP:1]};
      outBit  = acc[0];
    end else if (rot) begin
      accNext = {acc[WORD_W], acc[TOP:WORD_W+1], {WORD_W{1'b0}}};
      outBit  = acc[WORD_W];
    end else begin
      accNext = {acc[TOP], acc[TOP:WORD_W+1], {WORD_W{1'b0}}};
      outBit  = acc[WORD_W];
    end
    vNext = vReg | (~goRight & (acc[TOP] ^ acc[TOP-1]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc       <= '0;
      loHold    <= '0;
      modeCombo <= 1'b0;
      modeOdd   <= 1'b0;
      goRight   <= 1'b0;
      vReg      <= 1'b0;
      cReg      <= 1'b0;
    end else if (ctl.load) begin
      acc       <= (comboIn && !oddIn) ? {hiIn, loIn} : {hiIn, {WORD_W{1'b0}}};
      loHold    <= loIn;
      modeCombo <= comboIn;
      modeOdd   <= oddIn;
      goRight   <= rightIn;
      vReg      <= 1'b0;
      cReg      <= 1'b0;
    end else if (ctl.step) begin
      acc  <= accNext;
      vReg <= vNext;
      cReg <= outBit;
    end
  end

  assign hiOut = acc[TOP:WORD_W];
  assign loOut = wide ? acc[WORD_W-1:0] : (rot ? acc[TOP:WORD_W] : loHold);
  assign flagN = acc[TOP];
  assign flagZ = (acc == '0);
  assign flagV = vReg;
  assign flagC = cReg;

  // R5: arithmetic right shift keeps the sign bit
  assert_sign_keep_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && goRight && !rot) |=> (acc[TOP] == $past(acc[TOP])));

  // R4: rotation neither loses nor creates ones
  assert_rotate_bits_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && goRight && rot) |=> ($countones(acc) == $countones($past(acc))));

  // R6: once set during a left shift, V stays set
  assert_v_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && vReg) |=> vReg);

  // R6: right shifts never raise V
  assert_v_right_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && goRight) |=> !vReg);

  // R2: a new operation starts with clean V and C
  assert_load_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (!vReg && !cReg));

  // R3: in 16-bit modes the unused lower half never picks up bits
  assert_low_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    !wide |-> (acc[WORD_W-1:0] == '0));

endmodule

// File: rtl/arith_shift_unit.sv
module arith_shift_unit
  import ash_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic              comboMode,
  input  logic              oddReg,
  input  logic [WORD_W-1:0] hiIn,
  input  logic [WORD_W-1:0] loIn,
  input  logic [WORD_W-1:0] srcIn,
  output logic [WORD_W-1:0] hiOut,
  output logic [WORD_W-1:0] loOut,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagV,
  output logic              flagC,
  output logic              doneOut
);

  ashCtl_t ctl;
  logic    unusedSrcHigh;

  assign unusedSrcHigh = ^srcIn[WORD_W-1:CNT_W];

  ash_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .startIn (startIn),
    .countIn (srcIn[CNT_W-1:0]),
    .ctl     (ctl),
    .doneOut (doneOut)
  );

  ash_dp #(.WORD_W(WORD_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .comboIn (comboMode),
    .oddIn   (oddReg),
    .rightIn (srcIn[CNT_W-1]),
    .hiIn    (hiIn),
    .loIn    (loIn),
    .hiOut   (hiOut),
    .loOut   (loOut),
    .flagN   (flagN),
    .flagZ   (flagZ),
    .flagV   (flagV),
    .flagC   (flagC)
  );

endmodule

// File: tb/arith_shift_unit_bench.sv
`timescale 1ns/1ps
module arith_shift_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0;
  logic        comboMode = 1'b0;
  logic        oddReg = 1'b0;
  logic [15:0] hiIn = '0, loIn = '0, srcIn = '0;
  logic [15:0] hiOut, loOut;
  logic        flagN, flagZ, flagV, flagC, doneOut;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  arith_shift_unit u_arith_shift_unit (
    .clk(clk), .rstN(rstN), .startIn(startIn), .comboMode(comboMode), .oddReg(oddReg),
    .hiIn(hiIn), .loIn(loIn), .srcIn(srcIn), .hiOut(hiOut), .loOut(loOut),
    .flagN(flagN), .flagZ(flagZ), .flagV(flagV), .flagC(flagC), .doneOut(doneOut)
  );

  typedef struct packed {
    logic        combo;
    logic        odd;
    logic [15:0] hi;
    logic [15:0] lo;
    logic [15:0] src;
    logic [15:0] eHi;
    logic [15:0] eLo;
    logic [3:0]  eNzvc;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 16'h0003, 16'h1234, 16'h0004, 16'h0030, 16'h1234, 4'b0000, 4'd1 }, // R1 R3 left by 4
    '{1'b0, 1'b1, 16'h8001, 16'hAAAA, 16'h003F, 16'hC000, 16'hAAAA, 4'b1001, 4'd5 }, // R5 R7 R3 odd ignored
    '{1'b0, 1'b0, 16'h4000, 16'h0000, 16'h0001, 16'h8000, 16'h0000, 4'b1010, 4'd6 }, // R6 flip on first step
    '{1'b0, 1'b0, 16'h4000, 16'h0000, 16'h0002, 16'h0000, 16'h0000, 4'b0111, 4'd6 }, // R6 sticky, R7
    '{1'b0, 1'b0, 16'h8000, 16'h0000, 16'h0020, 16'hFFFF, 16'h0000, 4'b1001, 4'd5 }, // R5 distance -32
    '{1'b0, 1'b0, 16'h0001, 16'h0000, 16'h001F, 16'h0000, 16'h0000, 4'b0110, 4'd7 }, // R7 distance +31
    '{1'b1, 1'b0, 16'h0000, 16'h8000, 16'h0001, 16'h0001, 16'h0000, 4'b0000, 4'd9 }, // R9 carry across halves
    '{1'b1, 1'b0, 16'h8000, 16'h0001, 16'h003E, 16'hE000, 16'h0000, 4'b1000, 4'd9 }, // R9 R5 right by 2
    '{1'b1, 1'b1, 16'h0003, 16'h5555, 16'h003F, 16'h8001, 16'h8001, 4'b1001, 4'd4 }, // R4 R7 wrap bit
    '{1'b1, 1'b1, 16'h1234, 16'h5555, 16'h0030, 16'h1234, 16'h1234, 4'b0000, 4'd4 }, // R4 rotate by 16
    '{1'b1, 1'b1, 16'hC001, 16'h5555, 16'h0002, 16'h0004, 16'h0004, 4'b0011, 4'd12}, // R12 odd left
    '{1'b0, 1'b0, 16'h8000, 16'h0F0F, 16'hFFC0, 16'h8000, 16'h0F0F, 4'b1000, 4'd2 }, // R2 R1 upper bits ignored
    '{1'b1, 1'b0, 16'h0000, 16'h0000, 16'h0040, 16'h0000, 16'h0000, 4'b0100, 4'd2 }, // R2 R10 zero
    '{1'b1, 1'b0, 16'h0000, 16'h0001, 16'h0000, 16'h0000, 16'h0001, 4'b0000, 4'd10}  // R10 Z sees low half
  };

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Start one operation and return the number of edges until done is seen
  task automatic runOp(input logic combo, input logic odd, input logic [15:0] hi,
                       input logic [15:0] lo, input logic [15:0] src, output int edges);
    @(negedge clk);
    comboMode = combo; oddReg = odd; hiIn = hi; loIn = lo; srcIn = src; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    edges = 0;
    while (!doneOut && edges < 100) begin
      @(negedge clk);
      edges++;
    end
  endtask

  function automatic int magOf(input logic [5:0] c);
    return c[5] ? (64 - int'(c)) : int'(c);
  endfunction

  initial begin
    bit timedOut;
    timedOut = 1'b0;
    fork
      begin
        int edges;
        vec_t v;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", "hiOut after reset", {16'h0, hiOut}, 32'h0);
        check("R11", "loOut after reset", {16'h0, loOut}, 32'h0);
        check("R11", "doneOut after reset", {31'h0, doneOut}, 32'h0);
        rstN = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
          v = VECS[i];
          runOp(v.combo, v.odd, v.hi, v.lo, v.src, edges);
          check($sformatf("R%0d", v.req), $sformatf("vec%0d hiOut", i), {16'h0, hiOut}, {16'h0, v.eHi});
          check($sformatf("R%0d", v.req), $sformatf("vec%0d loOut", i), {16'h0, loOut}, {16'h0, v.eLo});
          check($sformatf("R%0d", v.req), $sformatf("vec%0d NZVC", i),
                {28'h0, flagN, flagZ, flagV, flagC}, {28'h0, v.eNzvc});
          check("R8", $sformatf("vec%0d latency", i), edges, magOf(v.src[5:0]));
          @(negedge clk);
          check("R8", $sformatf("vec%0d done width", i), {31'h0, doneOut}, 32'h0);
        end

        // R11: a second start during a run is ignored
        @(negedge clk);
        comboMode = 1'b0; oddReg = 1'b0; hiIn = 16'h0001; loIn = 16'h0000; srcIn = 16'h0008; startIn = 1'b1;
        @(negedge clk);
        startIn = 1'b0;
        edges = 0;
        @(negedge clk); edges++;
        hiIn = 16'hFFFF; srcIn = 16'h003F; startIn = 1'b1;
        @(negedge clk); edges++;
        startIn = 1'b0;
        while (!doneOut && edges < 100) begin
          @(negedge clk);
          edges++;
        end
        check("R11", "busy start result", {16'h0, hiOut}, 32'h0000_0100);
        check("R11", "busy start latency", edges, 8);
        @(negedge clk);
        check("R11", "no extra done after busy start", {31'h0, doneOut}, 32'h0);
        repeat (3) @(negedge clk);
        check("R11", "idle after ignored start", {31'h0, doneOut}, 32'h0);

        // R5: left shift fills zeros, right by one from -1 keeps all ones
        runOp(1'b0, 1'b0, 16'hFFFF, 16'h0000, 16'h0003, edges);
        check("R5", "left zero fill", {16'h0, hiOut}, 32'h0000_FFF8);
        runOp(1'b0, 1'b0, 16'hFFFF, 16'h0000, 16'h003F, edges);
        check("R5", "right sign fill", {16'h0, hiOut}, 32'h0000_FFFF);
        check("R6", "right clears V", {31'h0, flagV}, 32'h0);
      end
      begin
        repeat (150000) @(posedge clk);
        timedOut = 1'b1;
      end
    join_any
    disable fork;
    if (timedOut) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=timeout expected=finish");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule